// File: doc/BRIEF.md
# Secondary Interrupt Aggregator with Direct Forwarding

This block collects up to 32 level-sensitive interrupt sources. On every clock it registers them into a raw level vector. A single software-controlled bit is ORed into raw bit 0 alongside external source 0. The raw vector is ANDed with a programmable enable mask, and any surviving bit raises one combined request line toward a parent interrupt controller.

Sources in a fixed window (21 through 30 by default) can also be forwarded one by one to dedicated parent lines. A separate forwarding-enable register, with its own set and clear access, selects which of them are forwarded. A forwarded line copies the raw level of its source. A line whose forwarding bit is clear stays low.

Software reaches every register through a flat 32-bit register port. The port has a one-cycle write strobe, a read strobe with combinational read data, and a word index address. All enable registers are changed through set/clear write pairs, so there is no read-modify-write hazard.

Top module: `sic_router`

## Requirements
- R1: After reset, the enable mask, forwarding enables, soft bit and latched sources are all zero, `irq_o` and `pass_o` are low, and every read returns zero.
- R2: Reading word index 1 returns the raw level. Bits 31..1 equal `src_i` as sampled at the previous rising clock edge. Bit 0 is that sampled source 0 ORed with the soft bit.
- R3: A write to index 2 ORs `wdata_i` into the enable mask. A write to index 3 clears the mask bits that are set in `wdata_i`. Reading index 2 returns the mask.
- R4: Reading index 0 returns the raw level ANDed with the enable mask.
- R5: `irq_o` is high exactly when the raw level ANDed with the enable mask is nonzero.
- R6: A nonzero write to index 4 sets the soft bit, and a nonzero write to index 5 clears it. A zero write to either index changes nothing. Reading index 4 returns raw bit 0 in bit 0, with all other bits zero.
- R7: A write to index 8 sets forwarding-enable bits, but only within bits 21..30 (mask 0x7FE00000). A write to index 9 clears the forwarding bits that are set in `wdata_i`. Reading index 8 returns the forwarding-enable register.
- R8: `pass_o[k]` equals raw level bit 21+k while forwarding bit 21+k is set, and is low otherwise.
- R9: Reads of indices other than 0, 1, 2, 4 and 8 return zero. Writes to indices other than 2, 3, 4, 5, 8 and 9 change no state. `rdata_o` is zero while `rd_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Level-sensitive interrupt sources |
| wr_en_i | input | 1 | Single-cycle write strobe |
| rd_en_i | input | 1 | Read strobe; read data is combinational |
| addr_i | input | 4 | Word index of the register accessed |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, zero when not reading |
| irq_o | output | 1 | Combined masked request to the parent |
| pass_o | output | 10 | Forwarded lines for sources 21..30, bit k for source 21+k |

## Verification
Two kinds of update can land on the same clock edge. One is the capture of a new source vector. The other is a register write: a soft-bit write, an enable clear or a forwarding change. The bench provokes this by changing `src_i` in the same cycle as a write. Examples are dropping source 0 while setting the soft bit, and raising a windowed source while its forwarding bit is cleared. After that edge it compares the raw read, the masked read, `irq_o` and `pass_o` with a model that applies both updates together.

// File: rtl/sic_pkg.sv
package sic_pkg;

  localparam int unsigned SIC_W = 32;

  // register word indices
  localparam int unsigned IDX_PENDING  = 0;
  localparam int unsigned IDX_RAW      = 1;
  localparam int unsigned IDX_EN_SET   = 2;
  localparam int unsigned IDX_EN_CLR   = 3;
  localparam int unsigned IDX_SOFT_SET = 4;
  localparam int unsigned IDX_SOFT_CLR = 5;
  localparam int unsigned IDX_FWD_SET  = 8;
  localparam int unsigned IDX_FWD_CLR  = 9;

  typedef logic [SIC_W-1:0] word_t;

  function automatic word_t f_pending(input word_t raw, input word_t en);
    return raw & en;
  endfunction

  function automatic logic f_any(input word_t v);
    return |v;
  endfunction

  function automatic word_t f_window(input int unsigned lo, input int unsigned hi);
    word_t m;
    m = '0;
    for (int unsigned i = 0; i < SIC_W; i++) begin
      if (i >= lo && i <= hi) m[i] = 1'b1;
    end
    return m;
  endfunction

  function automatic word_t f_set(input word_t cur, input word_t val, input word_t allow);
    return cur | (val & allow);
  endfunction

  function automatic word_t f_clr(input word_t cur, input word_t val);
    return cur & ~val;
  endfunction

endpackage

// File: rtl/sic_src_latch.sv
module sic_src_latch #(
  parameter int unsigned W = sic_pkg::SIC_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic         soft_i,
  output logic [W-1:0] raw_o
);
  logic [W-1:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lat_q <= '0;
    else         lat_q <= src_i;
  end

  // soft request joins source 0
  assign raw_o = lat_q | W'(soft_i);
endmodule

// File: rtl/sic_ctrl_regs.sv
module sic_ctrl_regs
  import sic_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned PT_LO  = 21,
  parameter int unsigned PT_HI  = 30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  word_t             wdata_i,
  output word_t             en_q,
  output word_t             fwd_q,
  output logic              soft_q
);
  localparam word_t FWD_ALLOW = f_window(PT_LO, PT_HI);
  localparam word_t ALL_ONES  = '1;

  logic  nz;
  logic  ev_en_set, ev_en_clr, ev_soft_set, ev_soft_clr, ev_fwd_set, ev_fwd_clr;
  word_t en_d, fwd_d;
  logic  soft_d;

  assign nz          = f_any(wdata_i);
  assign ev_en_set   = wr_en_i && (addr_i == ADDR_W'(IDX_EN_SET));
  assign ev_en_clr   = wr_en_i && (addr_i == ADDR_W'(IDX_EN_CLR));
  assign ev_soft_set = wr_en_i && (addr_i == ADDR_W'(IDX_SOFT_SET)) && nz;
  assign ev_soft_clr = wr_en_i && (addr_i == ADDR_W'(IDX_SOFT_CLR)) && nz;
  assign ev_fwd_set  = wr_en_i && (addr_i == ADDR_W'(IDX_FWD_SET));
  assign ev_fwd_clr  = wr_en_i && (addr_i == ADDR_W'(IDX_FWD_CLR));

  always_comb begin
    en_d   = en_q;
    fwd_d  = fwd_q;
    soft_d = soft_q;
    if (ev_en_set)   en_d   = f_set(en_q, wdata_i, ALL_ONES);
    if (ev_en_clr)   en_d   = f_clr(en_q, wdata_i);
    if (ev_fwd_set)  fwd_d  = f_set(fwd_q, wdata_i, FWD_ALLOW);
    if (ev_fwd_clr)  fwd_d  = f_clr(fwd_q, wdata_i);
    if (ev_soft_set) soft_d = 1'b1;
    if (ev_soft_clr) soft_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      fwd_q  <= '0;
      soft_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      fwd_q  <= fwd_d;
      soft_q <= soft_d;
    end
  end
endmodule

// File: rtl/sic_read_mux.sv
module sic_read_mux
  import sic_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  word_t             raw_i,
  input  word_t             en_i,
  input  word_t             fwd_i,
  output word_t             rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (addr_i == ADDR_W'(IDX_PENDING))       rdata_o = f_pending(raw_i, en_i);
      else if (addr_i == ADDR_W'(IDX_RAW))      rdata_o = raw_i;
      else if (addr_i == ADDR_W'(IDX_EN_SET))   rdata_o = en_i;
      else if (addr_i == ADDR_W'(IDX_SOFT_SET)) rdata_o = SIC_W'(raw_i[0]);
      else if (addr_i == ADDR_W'(IDX_FWD_SET))  rdata_o = fwd_i;
    end
  end
endmodule

// File: rtl/sic_router.sv
module sic_router
  import sic_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned PT_LO  = 21,
  parameter int unsigned PT_HI  = 30,
  localparam int unsigned PT_CNT = PT_HI - PT_LO + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SIC_W-1:0]  src_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIC_W-1:0]  wdata_i,
  output logic [SIC_W-1:0]  rdata_o,
  output logic              irq_o,
  output logic [PT_CNT-1:0] pass_o
);
  word_t raw_lvl;
  word_t en_q;
  word_t fwd_q;
  logic  soft_q;

  sic_ctrl_regs #(.ADDR_W(ADDR_W), .PT_LO(PT_LO), .PT_HI(PT_HI)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .en_q    (en_q),
    .fwd_q   (fwd_q),
    .soft_q  (soft_q)
  );

  sic_src_latch #(.W(SIC_W)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .soft_i (soft_q),
    .raw_o  (raw_lvl)
  );

  sic_read_mux #(.ADDR_W(ADDR_W)) u_rmux (
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .raw_i   (raw_lvl),
    .en_i    (en_q),
    .fwd_i   (fwd_q),
    .rdata_o (rdata_o)
  );

  assign irq_o = f_any(f_pending(raw_lvl, en_q));

  for (genvar k = 0; k < PT_CNT; k++) begin : g_fwd
    assign pass_o[k] = raw_lvl[PT_LO+k] & fwd_q[PT_LO+k];
  end
endmodule

// File: rtl/sic_router_chk.sv
module sic_router_chk
  import sic_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned PT_LO  = 21,
  parameter int unsigned PT_CNT = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [SIC_W-1:0]  src_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [SIC_W-1:0]  wdata_i,
  input logic [SIC_W-1:0]  rdata_o,
  input logic              irq_o,
  input logic [PT_CNT-1:0] pass_o,
  input logic [SIC_W-1:0]  en_q,
  input logic [SIC_W-1:0]  fwd_q,
  input logic              soft_q,
  input logic [SIC_W-1:0]  raw_lvl
);
  logic wr_undef;
  assign wr_undef = wr_en_i &&
                    addr_i != ADDR_W'(IDX_EN_SET)   && addr_i != ADDR_W'(IDX_EN_CLR) &&
                    addr_i != ADDR_W'(IDX_SOFT_SET) && addr_i != ADDR_W'(IDX_SOFT_CLR) &&
                    addr_i != ADDR_W'(IDX_FWD_SET)  && addr_i != ADDR_W'(IDX_FWD_CLR);

  assert_en_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(IDX_EN_SET)) |=> ((en_q & $past(wdata_i)) == $past(wdata_i)));

  assert_en_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(IDX_EN_CLR)) |=> ((en_q & $past(wdata_i)) == '0));

  assert_irq_vs_pending_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == ADDR_W'(IDX_PENDING)) |-> (irq_o == (rdata_o != '0)));

  assert_raw_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (raw_lvl[SIC_W-1:1] == $past(src_i[SIC_W-1:1])));

  assert_soft_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(IDX_SOFT_SET) && wdata_i != '0) |=> (soft_q && raw_lvl[0]));

  assert_undef_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_undef |=> ($stable(en_q) && $stable(fwd_q) && $stable(soft_q)));

  assert_idle_rdata_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> (rdata_o == '0));

  for (genvar k = 0; k < PT_CNT; k++) begin : g_pchk
    assert_fwd_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i |=> (pass_o[k] |-> ($past(src_i[PT_LO+k]) && fwd_q[PT_LO+k])));
  end
endmodule

bind sic_router sic_router_chk #(.ADDR_W(ADDR_W), .PT_LO(PT_LO), .PT_CNT(PT_CNT)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .src_i   (src_i),
  .wr_en_i (wr_en_i),
  .rd_en_i (rd_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .pass_o  (pass_o),
  .en_q    (en_q),
  .fwd_q   (fwd_q),
  .soft_q  (soft_q),
  .raw_lvl (raw_lvl)
);

// File: tb/sic_router_tb.sv
module sic_router_tb_top;
  localparam int unsigned AW  = 4;
  localparam int unsigned LO  = 21;
  localparam int unsigned CNT = 10;
  localparam logic [31:0] FWD_WIN = 32'h7FE0_0000;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [31:0]   src = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;
  logic [CNT-1:0] pass;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference state
  logic [31:0] m_lat = '0;
  logic [31:0] m_en = '0;
  logic [31:0] m_fwd = '0;
  logic        m_soft = 1'b0;

  always #5 clk = ~clk;

  sic_router dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .pass_o(pass)
  );

  function automatic logic [31:0] m_raw();
    return m_lat | {31'b0, m_soft};
  endfunction

  function automatic logic [31:0] exp_read(input int a);
    logic [31:0] r;
    r = m_raw();
    case (a)
      0: return r & m_en;
      1: return r;
      2: return m_en;
      4: return {31'b0, r[0]};
      8: return m_fwd;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [CNT-1:0] exp_pass();
    logic [CNT-1:0] p;
    logic [31:0] r;
    r = m_raw();
    for (int k = 0; k < CNT; k++) p[k] = r[LO+k] && m_fwd[LO+k];
    return p;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic read_chk(input int a, input string req);
    addr  = AW'(a);
    rd_en = 1'b1;
    #1;
    check(req, rdata, exp_read(a));
    rd_en = 1'b0;
    addr  = '0;
    #1;
  endtask

  task automatic check_all(input string tag);
    check({tag, " R5 irq"}, {31'b0, irq}, {31'b0, |(m_raw() & m_en)});
    check({tag, " R8 pass"}, {22'b0, pass}, {22'b0, exp_pass()});
    check({tag, " R9 idle rdata"}, rdata, 32'h0);
    read_chk(0, {tag, " R4 pending"});
    read_chk(1, {tag, " R2 raw"});
    read_chk(2, {tag, " R3 mask"});
    read_chk(4, {tag, " R6 soft read"});
    read_chk(8, {tag, " R7 fwd"});
    for (int a = 0; a < 16; a++) begin
      if (a != 0 && a != 1 && a != 2 && a != 4 && a != 8) read_chk(a, {tag, " R9 undef read"});
    end
  endtask

  // one clock: optional write, new source vector; called just after a falling edge
  task automatic step(input logic do_wr, input int a, input logic [31:0] d, input logic [31:0] s);
    src   = s;
    wr_en = do_wr;
    addr  = AW'(a);
    wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    addr  = '0;
    wdata = '0;
    m_lat = s;
    if (do_wr) begin
      case (a)
        2: m_en  = m_en | d;
        3: m_en  = m_en & ~d;
        4: if (d != 0) m_soft = 1'b1;
        5: if (d != 0) m_soft = 1'b0;
        8: m_fwd = m_fwd | (d & FWD_WIN);
        9: m_fwd = m_fwd & ~d;
        default: ;
      endcase
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int defs[6];
    defs = '{2, 3, 4, 5, 8, 9};
    void'($urandom(32'h5EED_0C11));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // R1 reset state
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    check("R1 pass after reset", {22'b0, pass}, 32'h0);
    check_all("R1");

    // R3 mask set/clear
    step(1, 2, 32'hF0F0_0001, 32'h0);
    check_all("R3 set");
    step(1, 3, 32'h00F0_0000, 32'h0);
    check_all("R3 clr");

    // R2/R4/R5 sources
    step(0, 0, 0, 32'h1000_0000);
    check_all("R5 src");
    step(0, 0, 0, 32'h0F00_0000);
    check_all("R4 unmasked src");

    // R6 soft: zero write ignored, then set, then clear
    step(1, 4, 32'h0, 32'h0);
    check_all("R6 zero set");
    step(1, 4, 32'h0000_0100, 32'h0);
    check_all("R6 set");
    step(1, 5, 32'h0, 32'h0);
    check_all("R6 zero clr");
    step(1, 5, 32'h8000_0000, 32'h0);
    check_all("R6 clr");

    // R7 window limit, R8 forwarding
    step(1, 8, 32'hFFFF_FFFF, 32'h0);
    check_all("R7 set all");
    step(0, 0, 0, 32'h5540_0000);
    check_all("R8 follow");
    step(1, 9, 32'h0140_0000, 32'h5540_0000);
    check_all("R8 partial clear");

    // same-cycle: source 0 drops while soft set lands
    step(0, 0, 0, 32'h0000_0001);
    step(1, 4, 32'h1, 32'h0);
    check_all("R2 same-cycle soft");
    // same-cycle: windowed source rises while its forwarding bit clears
    step(1, 9, 32'h4000_0000, 32'h7FE0_0000);
    check_all("R8 same-cycle clear");
    // undefined writes
    step(1, 6, 32'hFFFF_FFFF, 32'h7FE0_0000);
    check_all("R9 undef write");
    step(1, 0, 32'hFFFF_FFFF, 32'h0);
    check_all("R9 write status");

    // constrained random
    for (int it = 0; it < 250; it++) begin
      int op;
      int a;
      logic [31:0] d;
      logic [31:0] s;
      op = int'($urandom % 4);
      d  = ($urandom % 5 == 0) ? 32'h0 : $urandom;
      s  = $urandom;
      a  = defs[$urandom % 6];
      case (op)
        0: step(0, 0, 0, s);
        1: step(1, a, d, m_lat);
        2: step(1, int'($urandom % 16), d, m_lat);
        default: step(1, a, d, s);
      endcase
      check_all("RND");
    end

    finish_run();
  end
endmodule